// File: doc/BRIEF.md
# Serial Programming Port for On-Chip Program Memory

This block is a slave-side serial programming port. While the device reset input is held high, an external programmer clocks 32-bit instruction frames in on a data line, one bit per rising edge of its serial clock. The block answers on a return data line during the last byte of each frame. The serial clock is oversampled by the system clock, so there is no second clock domain inside the block. Both serial inputs pass through two-flop synchronizers, and the clock edges are found in the system clock domain.

Each frame is four bytes, most significant bit first. The first byte is the opcode. Frames can unlock the port, erase the whole memory, write one byte, read one byte, read the three-byte device signature, or set lock bits. The block drives a byte-wide port toward an 8K-byte program memory, addressed 0x0000 to 0x1FFF. That memory has a registered read of one cycle. The block also holds the lock-bit register. Each write-type operation holds a busy window of fixed length. Write-type frames that arrive during that window are dropped.

Top module: `isp_serial_port`

## Requirements
- R1: With prog_rst low, miso stays 0 and frames have no effect. Taking prog_rst low clears the enabled state and any partly received frame, so the next frame after prog_rst returns high is aligned from its first bit.
- R2: Until an enable frame has been received, write, erase and lock frames produce no strobe and no lock change. Byte and signature reads return 0x00.
- R3: The enable frame is 0xAC, 0x53, any, any. It sets prog_en, and during its fourth byte miso echoes the frame's third byte.
- R4: The byte write frame is 0x40, address high, address low, data. It issues one mem_we pulse of one cycle, with mem_wdata equal to the data byte and mem_addr equal to the low 13 bits of {address high, address low}. The upper three bits of address high are ignored. It then holds busy for WR_CYCLES cycles.
- R5: The byte read frame is 0x20, address high, address low, any. It returns the stored byte at the 13-bit address on miso during the fourth byte.
- R6: The signature frame is 0x28, any, index, any. Index bits [1:0] = 0, 1 and 2 return 0x1E, 0x52 and 0x06 respectively, and 3 returns 0xFF.
- R7: The lock frame is 0xAC, 0b111xxxab, any, any. It ORs bits ab into lock_q[1:0] and holds busy for WR_CYCLES cycles. Only an erase clears a lock bit. While lock_q[1] is set, byte reads return 0xFF.
- R8: The erase frame is 0xAC, 0b100xxxxx, any, any. It issues one mem_erase pulse, clears lock_q in the same cycle, and holds busy for ER_CYCLES cycles.
- R9: A write, erase or lock frame that completes while busy is high is dropped without effect.
- R10: miso changes only while the synchronized serial clock is low. It is therefore stable across every rising edge at which the programmer samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the serial clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prog_rst | input | 1 | Device reset pin; the port is active while this is high |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data in, sampled on the rising edge of sck |
| miso | output | 1 | Serial data out, updated after the falling edge of sck |
| mem_addr | output | 13 | Program memory address |
| mem_wdata | output | 8 | Program memory write data |
| mem_we | output | 1 | One-cycle byte write strobe |
| mem_erase | output | 1 | One-cycle chip erase strobe |
| mem_rdata | input | 8 | Program memory read data, one cycle after mem_addr |
| busy | output | 1 | Write or erase cycle in progress |
| prog_en | output | 1 | Programming enable has been received |
| lock_q | output | 2 | Lock bits; bit 1 blocks reads |

## Verification
Two things can fall in the same cycle: the completion of a new write-type frame and a busy window that is still running from the previous write. The write cycle is longer than one frame, so sending two writes back to back provokes the overlap. The outcome is judged by the strobe counts, which must rise by exactly one, and by reading back the second address, which must still hold its erased value. The same check is repeated with a lock frame sent inside an erase window. Random write, read and signature traffic runs against a bench model of the memory. Further directed cases cover locking, masking of the address, and leaving reset partway through a frame.

// File: rtl/isp_serial_port.sv
module isp_serial_port #(
  parameter int ADDR_W    = 13,
  parameter int WR_CYCLES = 1000,
  parameter int ER_CYCLES = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_rst,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_erase,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              prog_en,
  output logic [1:0]        lock_q
);
  localparam int MAXC = (ER_CYCLES > WR_CYCLES) ? ER_CYCLES : WR_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [7:0] OP_ISP = 8'hAC, OP_RD = 8'h20, OP_WR = 8'h40, OP_SIG = 8'h28;
  localparam logic [7:0] EN_KEY = 8'h53;

  logic [2:0]    sck_s;
  logic [1:0]    mosi_s;
  logic [30:0]   sh;
  logic [4:0]    bcnt;
  logic [7:0]    ob;
  logic [1:0]    rd_pipe;
  logic [CW-1:0] busy_cnt;
  logic [7:0]    hd_byte;
  logic          hd_read;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s  <= '0;
      mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      mosi_s <= {mosi_s[0], mosi};
    end

  wire        rise = sck_s[1] & ~sck_s[2];
  wire        fall = ~sck_s[1] & sck_s[2];
  wire [31:0] nxt  = {sh, mosi_s[1]};

  wire [7:0] h_op = nxt[23:16];
  wire [7:0] h_b2 = nxt[15:8];
  wire [7:0] f_op = nxt[31:24];
  wire [7:0] f_b2 = nxt[23:16];

  wire f_en    = (f_op == OP_ISP) && (f_b2 == EN_KEY);
  wire f_erase = (f_op == OP_ISP) && (f_b2[7:5] == 3'b100);
  wire f_lock  = (f_op == OP_ISP) && (f_b2[7:5] == 3'b111);
  wire f_write = (f_op == OP_WR);
  wire act     = prog_en && !busy;

  assign busy = (busy_cnt != '0);

  always_comb begin
    hd_byte = 8'h00;
    hd_read = 1'b0;
    if (h_op == OP_ISP && h_b2 == EN_KEY) hd_byte = nxt[7:0];
    else if (prog_en) begin
      if (h_op == OP_SIG) begin
        case (nxt[1:0])
          2'd0:    hd_byte = 8'h1E;
          2'd1:    hd_byte = 8'h52;
          2'd2:    hd_byte = 8'h06;
          default: hd_byte = 8'hFF;
        endcase
      end else if (h_op == OP_RD) begin
        if (lock_q[1]) hd_byte = 8'hFF;
        else           hd_read = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0; bcnt <= '0; ob <= '0; miso <= 1'b0; rd_pipe <= '0;
      mem_addr <= '0; mem_wdata <= '0; mem_we <= 1'b0; mem_erase <= 1'b0;
      busy_cnt <= '0; prog_en <= 1'b0; lock_q <= '0;
    end else begin
      mem_we    <= 1'b0;
      mem_erase <= 1'b0;
      rd_pipe   <= {rd_pipe[0], 1'b0};
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (rd_pipe[1]) ob <= mem_rdata;
      if (!prog_rst) begin
        prog_en <= 1'b0; bcnt <= '0; sh <= '0; ob <= '0; miso <= 1'b0; rd_pipe <= '0;
      end else begin
        if (rise) begin
          sh   <= nxt[30:0];
          bcnt <= bcnt + 1'b1;
          if (bcnt == 5'd23) begin
            ob <= hd_byte;
            if (hd_read) begin
              mem_addr <= nxt[ADDR_W-1:0];
              rd_pipe  <= 2'b01;
            end
          end
          if (bcnt == 5'd31) begin
            if (f_en) prog_en <= 1'b1;
            else if (act) begin
              if (f_erase) begin
                mem_erase <= 1'b1;
                lock_q    <= '0;
                busy_cnt  <= CW'(ER_CYCLES);
              end else if (f_lock) begin
                lock_q   <= lock_q | f_b2[1:0];
                busy_cnt <= CW'(WR_CYCLES);
              end else if (f_write) begin
                mem_addr  <= nxt[ADDR_W+7:8];
                mem_wdata <= nxt[7:0];
                mem_we    <= 1'b1;
                busy_cnt  <= CW'(WR_CYCLES);
              end
            end
          end
        end
        if (fall) begin
          miso <= (bcnt >= 5'd24) ? ob[7] : 1'b0;
          if (bcnt >= 5'd24) ob <= {ob[6:0], 1'b0};
        end
      end
    end

  a_r1_idle_outside_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_rst && !$past(prog_rst)) |-> (!miso && !mem_we && !mem_erase));
  a_r2_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_erase) |-> prog_en);
  a_r4_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  a_r7_lock_clears_only_on_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lock_q) & ~lock_q) != 2'b00) |-> mem_erase);
  a_r8_erase_clears_lock: assert property (@(posedge clk) disable iff (!rst_n)
    mem_erase |-> (lock_q == 2'b00 && busy));
  a_r9_no_strobe_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_erase) |-> !$past(busy));
  a_r10_miso_moves_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_rst && $past(prog_rst) && miso != $past(miso)) |-> !sck_s[1]);
endmodule

// File: tb/sim_isp_serial_port.sv
module sim_isp_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0, prog_rst = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, mem_we, mem_erase, busy, prog_en;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [1:0]  lock_q;

  int checks = 0, failures = 0, stab_err = 0, we_n = 0, er_n = 0;
  bit done = 1'b0;
  logic [7:0] mem [int];
  logic [7:0] exp_mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  isp_serial_port u0 (.clk(clk), .rst_n(rst_n), .prog_rst(prog_rst), .sck(sck), .mosi(mosi),
    .miso(miso), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_erase(mem_erase), .mem_rdata(mem_rdata), .busy(busy), .prog_en(prog_en), .lock_q(lock_q));

  always @(posedge clk) begin
    if (mem_erase) begin mem.delete(); er_n++; end
    else if (mem_we) begin mem[int'(mem_addr)] = mem_wdata; we_n++; end
    mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hFF;
  end

  function automatic logic [7:0] model_rd(int a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'hFF;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] f, output logic [7:0] rx);
    logic pre;
    rx = 8'h00; pre = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      mosi = f[i];
      repeat (HALF) @(negedge clk);
      if (i < 8) begin rx[i] = miso; pre = miso; end
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i < 8 && miso !== pre) stab_err++;
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] rx;
    int w0, e0;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset state", {miso, busy, prog_en, lock_q}, 5'b0);

    // R2: nothing acted on before enable
    xfer({8'h40, 8'h00, 8'h10, 8'h55}, rx);
    xfer({8'hAC, 8'h80, 8'h00, 8'h00}, rx);
    xfer({8'hAC, 8'hE3, 8'h00, 8'h00}, rx);
    chk("R2 no strobes before enable", {we_n[7:0], er_n[7:0], 6'b0, lock_q}, 24'h0);
    xfer({8'h28, 8'h00, 8'h00, 8'h00}, rx);
    chk("R2 signature before enable", rx, 8'h00);

    // R3
    xfer({8'hAC, 8'h53, 8'hA5, 8'h00}, rx);
    chk("R3 enable echo", rx, 8'hA5);
    chk("R3 prog_en set", prog_en, 1'b1);

    // R4 R5: top address and masking
    xfer({8'h40, 8'h1F, 8'hFF, 8'h3C}, rx);
    exp_mem[13'h1FFF] = 8'h3C;
    chk("R4 busy after write", busy, 1'b1);
    wait_idle();
    xfer({8'h40, 8'hE0, 8'h05, 8'h9A}, rx);
    exp_mem[5] = 8'h9A;
    wait_idle();
    xfer({8'h20, 8'h1F, 8'hFF, 8'h00}, rx);
    chk("R5 read top address", rx, 8'h3C);
    xfer({8'h20, 8'h00, 8'h05, 8'h00}, rx);
    chk("R4 masked address", rx, 8'h9A);

    // R6
    for (int k = 0; k < 4; k++) begin
      xfer({8'h28, 8'h00, 8'(k), 8'h00}, rx);
      chk("R6 signature", rx, (k == 0) ? 8'h1E : (k == 1) ? 8'h52 : (k == 2) ? 8'h06 : 8'hFF);
    end

    // R9: second write lands during busy window
    w0 = we_n;
    xfer({8'h40, 8'h00, 8'h40, 8'h11}, rx);
    exp_mem[13'h0040] = 8'h11;
    xfer({8'h40, 8'h00, 8'h41, 8'h22}, rx);
    chk("R9 write during busy dropped (strobes)", we_n - w0, 1);
    wait_idle();
    xfer({8'h20, 8'h00, 8'h41, 8'h00}, rx);
    chk("R9 dropped write leaves memory", rx, 8'hFF);
    xfer({8'h20, 8'h00, 8'h40, 8'h00}, rx);
    chk("R5 read first write", rx, 8'h11);

    // R7
    xfer({8'hAC, 8'hE2, 8'h00, 8'h00}, rx);
    chk("R7 lock bit 1 set", lock_q, 2'b10);
    wait_idle();
    xfer({8'h20, 8'h00, 8'h40, 8'h00}, rx);
    chk("R7 read blocked by lock", rx, 8'hFF);
    xfer({8'hAC, 8'hE1, 8'h00, 8'h00}, rx);
    chk("R7 lock bits accumulate", lock_q, 2'b11);
    wait_idle();

    // R8 then R9 with a lock frame inside the erase window
    e0 = er_n;
    xfer({8'hAC, 8'h80, 8'h00, 8'h00}, rx);
    exp_mem.delete();
    chk("R8 erase clears lock", lock_q, 2'b00);
    chk("R8 busy during erase", busy, 1'b1);
    xfer({8'hAC, 8'hE2, 8'h00, 8'h00}, rx);
    chk("R9 lock during erase dropped", lock_q, 2'b00);
    chk("R8 one erase strobe", er_n - e0, 1);
    wait_idle();
    xfer({8'h20, 8'h00, 8'h05, 8'h00}, rx);
    chk("R8 memory erased", rx, 8'hFF);

    // R1: leave reset mid-frame
    for (int i = 31; i >= 20; i--) begin
      mosi = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b0;
    end
    prog_rst = 1'b0;
    repeat (HALF) @(negedge clk);
    chk("R1 enable cleared", prog_en, 1'b0);
    xfer({8'h40, 8'h00, 8'h07, 8'h77}, rx);
    chk("R1 miso idle outside reset", rx, 8'h00);
    prog_rst = 1'b1;
    repeat (HALF) @(negedge clk);
    xfer({8'h28, 8'h00, 8'h00, 8'h00}, rx);
    chk("R1 R2 disabled after reset exit", rx, 8'h00);
    xfer({8'hAC, 8'h53, 8'h3E, 8'h00}, rx);
    chk("R1 frame aligned after reset exit", rx, 8'h3E);

    // random traffic
    for (int n = 0; n < 40; n++) begin
      int op, a;
      logic [7:0] b2, d;
      op = $urandom % 3;
      a  = ((($urandom % 8) * 32'h357) + 32'h100) & 32'h1FFF;
      b2 = {3'($urandom), 5'(a >> 8)};
      d  = 8'($urandom);
      if (op == 0) begin
        wait_idle();
        xfer({8'h40, b2, 8'(a), d}, rx);
        exp_mem[a] = d;
      end else if (op == 1) begin
        xfer({8'h20, b2, 8'(a), 8'h00}, rx);
        chk("R5 random read", rx, model_rd(a));
      end else begin
        xfer({8'h28, b2, d, 8'h00}, rx);
        chk("R6 random signature", rx,
            (d[1:0] == 2'd0) ? 8'h1E : (d[1:0] == 2'd1) ? 8'h52 : (d[1:0] == 2'd2) ? 8'h06 : 8'hFF);
      end
    end

    chk("R10 miso stable across sck rise", stab_err, 0);
    summary();
  end
endmodule